// File: doc/BRIEF.md
# Single-Accumulator Instruction Engine with Conditional Branch

This block is a small processor that completes one instruction on every rising clock edge. Its program sits in an on-chip ROM whose contents are given as a parameter array. The datapath is one accumulator, a zero flag and a bank of eight general registers. It has no data memory and no external bus. The program counter, the accumulator and the zero flag are brought out on debug ports, so the surrounding logic or a bench can follow execution. The registers can only be seen through their effect on the accumulator.

The instruction set has five operations: an absolute jump, a store of the accumulator into a register, an add of an immediate value, a bitwise AND with a register, and a jump taken only when the zero flag is set. Any other opcode does nothing except advance the program counter. A jump, or a branch that is taken, replaces the program counter. Every other instruction moves it on by one. The counter wraps at the ROM depth.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, the program counter, the accumulator, the zero flag and all eight registers are cleared at once, without waiting for a clock edge. Clock edges during reset change nothing.
- R2: An instruction is 16 bits wide. Bits [15:12] hold the opcode and bits [11:0] hold the operand. The codes are 1 = jump, 2 = store, 3 = add immediate, 4 = AND register and 5 = branch if zero. The register index is operand bits [2:0].
- R3: A jump loads the program counter from the low log2(ROM_DEPTH) bits of the operand. Higher operand bits are ignored, so operand 0x0FF with a 16-entry ROM goes to address 15.
- R4: A store writes the accumulator into the selected register. The accumulator and the zero flag are unchanged.
- R5: An add immediate adds the zero-extended 12-bit operand to the accumulator, modulo 2^DATA_W.
- R6: An AND register replaces the accumulator with the bitwise AND of the accumulator and the selected register. The value read is the one written by any earlier instruction.
- R7: A branch if zero loads the program counter from the operand's low address bits when the zero flag is 1. When the flag is 0, the program counter moves on by one.
- R8: Every instruction other than a jump or a taken branch increments the program counter by one, wrapping from ROM_DEPTH-1 to 0.
- R9: An add immediate or an AND register sets the zero flag to 1 exactly when its result is zero, and to 0 otherwise. Every other instruction leaves the flag unchanged.
- R10: Opcodes 0 and 6 to 15 change neither the accumulator, nor the flag, nor any register. They only increment the program counter.
- R11: Exactly one instruction completes on each rising clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| pc_o | output | $clog2(ROM_DEPTH) | Address of the instruction now executing |
| acc_o | output | DATA_W | Accumulator value |
| zero_o | output | 1 | Zero flag |

## Verification
Two functions meet at one edge: the accumulator operation that writes the zero flag, and the branch right after it that reads the flag. At that edge the branch must see the flag just written, not an older value. The program arranges both outcomes. A register AND that gives zero is followed by a taken branch. A later add that gives a nonzero result is followed by a branch that falls through. A store placed between the flag write and the branch shows that the flag is held across it. Each outcome is judged by the debug program counter one cycle later. A second pass through the same code reads a register stored late in the first pass, so the register AND gives a different result there. After a reset in the middle of the run, the first-pass result returns, which shows that the register bank was cleared.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int OPND_W  = INSTR_W - OPC_W;

  typedef enum logic [OPC_W-1:0] {
    OPC_JMP  = 4'h1,
    OPC_STR  = 4'h2,
    OPC_ADDI = 4'h3,
    OPC_ANDR = 4'h4,
    OPC_BZ   = 4'h5
  } opcode_e;

  typedef enum logic { ALU_ADD = 1'b0, ALU_AND = 1'b1 } alu_sel_e;

  typedef struct packed {
    logic     is_jmp;
    logic     is_bz;
    logic     reg_wr;
    logic     acc_wr;
    alu_sel_e alu_sel;
  } ctrl_t;
endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);
  logic [OPC_W-1:0] opc;
  assign opc = instr[INSTR_W-1 -: OPC_W];

  always_comb begin
    ctrl = '{is_jmp: 1'b0, is_bz: 1'b0, reg_wr: 1'b0, acc_wr: 1'b0, alu_sel: ALU_ADD};
    case (opc)
      OPC_JMP:  ctrl.is_jmp = 1'b1;
      OPC_STR:  ctrl.reg_wr = 1'b1;
      OPC_ADDI: ctrl.acc_wr = 1'b1;
      OPC_ANDR: begin
        ctrl.acc_wr  = 1'b1;
        ctrl.alu_sel = ALU_AND;
      end
      OPC_BZ:   ctrl.is_bz = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [OPND_W-1:0] imm,
  input  logic [DATA_W-1:0] reg_val,
  input  alu_sel_e          sel,
  output logic [DATA_W-1:0] result,
  output logic              is_zero
);
  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = DATA_W'(imm);

  always_comb begin
    if (sel == ALU_AND) result = acc & reg_val;
    else                result = acc + imm_ext;
    is_zero = (result == '0);
  end
endmodule

// File: rtl/acc_cpu_regfile.sv
module acc_cpu_regfile #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 8,
  localparam int SEL_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs_q [REG_CNT];

  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
    logic en;
    assign en = wr_en && (waddr == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[i] <= '0;
      else if (en) regs_q[i] <= wdata;
    end
  end

  assign rdata = regs_q[raddr];

  // R4: the selected register holds the stored value after the edge
  p_store_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(waddr)] == $past(wdata));

  // R1: the whole bank is clear while reset is held
  p_bank_clear_r1: assert property (@(posedge clk)
    !rst_n |-> rdata == '0);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int REG_CNT   = 8,
  parameter int ROM_DEPTH = 16,
  parameter logic [INSTR_W-1:0] PROG [ROM_DEPTH] = '{default: '0}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [$clog2(ROM_DEPTH)-1:0] pc_o,
  output logic [DATA_W-1:0]            acc_o,
  output logic                         zero_o
);
  localparam int PC_W  = $clog2(ROM_DEPTH);
  localparam int SEL_W = $clog2(REG_CNT);

  logic [PC_W-1:0]    pc_q, pc_d;
  logic [DATA_W-1:0]  acc_q, acc_d;
  logic               zero_q, zero_d;
  logic               acc_en;
  logic [INSTR_W-1:0] instr;
  ctrl_t              ctl;
  logic [DATA_W-1:0]  reg_val, alu_res;
  logic               alu_zero;
  logic [SEL_W-1:0]   rsel;
  logic [PC_W-1:0]    target;

  assign instr  = PROG[pc_q];
  assign rsel   = instr[SEL_W-1:0];
  assign target = instr[PC_W-1:0];

  acc_cpu_decode u_dec (
    .instr (instr),
    .ctrl  (ctl)
  );

  acc_cpu_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ctl.reg_wr),
    .waddr (rsel),
    .wdata (acc_q),
    .raddr (rsel),
    .rdata (reg_val)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .acc     (acc_q),
    .imm     (instr[OPND_W-1:0]),
    .reg_val (reg_val),
    .sel     (ctl.alu_sel),
    .result  (alu_res),
    .is_zero (alu_zero)
  );

  always_comb begin
    pc_d   = pc_q + 1'b1;
    if (ctl.is_jmp || (ctl.is_bz && zero_q)) pc_d = target;
    acc_en = ctl.acc_wr;
    acc_d  = alu_res;
    zero_d = alu_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      zero_q <= 1'b0;
    end else if (acc_en) begin
      acc_q  <= acc_d;
      zero_q <= zero_d;
    end
  end

  assign pc_o   = pc_q;
  assign acc_o  = acc_q;
  assign zero_o = zero_q;

  // R8: sequential flow advances by one, wrapping at the ROM depth
  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.is_jmp || ctl.is_bz) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

  // R3: a jump lands on its address field
  p_jump_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.is_jmp |=> pc_q == $past(target));

  // R7: a branch with the flag set is taken
  p_bz_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.is_bz && zero_q) |=> pc_q == $past(target));

  // R7: a branch with the flag clear falls through
  p_bz_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.is_bz && !zero_q) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

  // R9: the flag and the accumulator hold when not written
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.acc_wr |=> $stable(zero_q) && $stable(acc_q));

  // R9: after an accumulator write the flag matches the new value
  p_flag_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.acc_wr |=> zero_q == (acc_q == '0));

  // R1: state is clear while reset is held
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (pc_q == '0 && acc_q == '0 && !zero_q));
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int DEPTH      = 16;

  // R2: opcode in [15:12], operand in [11:0]
  localparam logic [15:0] TB_PROG [DEPTH] = '{
    16'h3005,  //  0 add 5
    16'h2003,  //  1 store r3
    16'h4003,  //  2 and r3
    16'h5009,  //  3 bz 9
    16'h4002,  //  4 and r2
    16'h5008,  //  5 bz 8
    16'h3003,  //  6 add 3
    16'h10FF,  //  7 jmp, upper bits set -> 15
    16'h3FFF,  //  8 add 4095
    16'h2002,  //  9 store r2
    16'hF123,  // 10 undefined
    16'h3001,  // 11 add 1
    16'h4002,  // 12 and r2
    16'h2005,  // 13 store r5
    16'h5006,  // 14 bz 6
    16'h5000   // 15 bz 0
  };

  typedef struct packed {
    logic [3:0]  pc;
    logic [15:0] acc;
    logic        z;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  16'd5,    1'b0, 4'd5},   // R5 add
    '{4'd2,  16'd5,    1'b0, 4'd4},   // R4 store keeps acc
    '{4'd3,  16'd5,    1'b0, 4'd6},   // R6 and with stored reg
    '{4'd4,  16'd5,    1'b0, 4'd7},   // R7 branch falls through
    '{4'd5,  16'd0,    1'b1, 4'd9},   // R9 zero result sets flag
    '{4'd8,  16'd0,    1'b1, 4'd7},   // R7 branch taken
    '{4'd9,  16'd4095, 1'b0, 4'd9},   // R9 nonzero clears flag
    '{4'd10, 16'd4095, 1'b0, 4'd4},   // R4 store
    '{4'd11, 16'd4095, 1'b0, 4'd10},  // R10 undefined opcode
    '{4'd12, 16'd4096, 1'b0, 4'd5},   // R5 add past 12 bits
    '{4'd13, 16'd0,    1'b1, 4'd6},   // R6 and to zero
    '{4'd14, 16'd0,    1'b1, 4'd9},   // R9 flag held over store
    '{4'd6,  16'd0,    1'b1, 4'd7},   // R7 taken after store
    '{4'd7,  16'd3,    1'b0, 4'd5},   // R5
    '{4'd15, 16'd3,    1'b0, 4'd3},   // R3 upper address bits ignored
    '{4'd0,  16'd3,    1'b0, 4'd8},   // R8 wrap 15 -> 0
    '{4'd1,  16'd8,    1'b0, 4'd5},   // R5
    '{4'd2,  16'd8,    1'b0, 4'd4},   // R4
    '{4'd3,  16'd8,    1'b0, 4'd6},   // R6
    '{4'd4,  16'd8,    1'b0, 4'd7},   // R7
    '{4'd5,  16'd8,    1'b0, 4'd6},   // R6 reads r2 written earlier
    '{4'd6,  16'd8,    1'b0, 4'd7},   // R7 falls through
    '{4'd7,  16'd11,   1'b0, 4'd11},  // R11 one per edge
    '{4'd15, 16'd11,   1'b0, 4'd3},   // R3
    '{4'd0,  16'd11,   1'b0, 4'd8}    // R8
  };

  logic              clk;
  logic              rst_n;
  logic [3:0]        pc_o;
  logic [DATA_W-1:0] acc_o;
  logic              zero_o;
  int                n_chk;
  int                n_bad;

  acc_cpu #(.DATA_W(DATA_W), .REG_CNT(8), .ROM_DEPTH(DEPTH), .PROG(TB_PROG)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_o   (pc_o),
    .acc_o  (acc_o),
    .zero_o (zero_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [3:0] pc_e,
                       input logic [15:0] acc_e, input logic z_e);
    n_chk++;
    if (pc_o !== pc_e || acc_o !== acc_e || zero_o !== z_e) begin
      n_bad++;
      $display("FAIL %s: pc=%0d acc=%0d z=%0b expected pc=%0d acc=%0d z=%0b",
               tag, pc_o, acc_o, zero_o, pc_e, acc_e, z_e);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    n_chk++;
    n_bad++;
    $display("FAIL R11: watchdog expired, actual=hung expected=done");
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    step(2);
    check("R1 reset state", 4'd0, 16'd0, 1'b0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      step(1);
      check($sformatf("R%0d vector %0d", VECS[v].req, v),
            VECS[v].pc, VECS[v].acc, VECS[v].z);
    end

    // R1: asynchronous clear mid-run, between edges
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", 4'd0, 16'd0, 1'b0);
    step(2);
    check("R1 edges ignored in reset", 4'd0, 16'd0, 1'b0);
    rst_n = 1'b1;

    // R11: first edge after release executes address 0
    step(1);
    check("R11 first instruction", 4'd1, 16'd5, 1'b0);
    // R1: r2 was 4095 before reset; cleared bank makes the AND zero
    step(4);
    check("R1 register bank cleared", 4'd5, 16'd0, 1'b1);
    step(1);
    check("R7 taken after reset", 4'd8, 16'd0, 1'b1);

    finish_run();
  end
endmodule